// File: doc/BRIEF.md
# Two-Phase Window Watchdog

This block is a memory-mapped watchdog whose timing runs in two phases. Once armed, a down-counter first runs through a closed phase, in which a restart is forbidden. It then runs through an open phase, in which software must restart it. Each phase length is set by its own 32-bit count register.

A restart in the open phase begins a fresh closed phase. A restart attempt during the closed phase is a fault. So is letting the open phase run out. On a fault the block emits a one-cycle system reset request, raises a sticky interrupt flag and freezes until the next synchronous reset.

Software reaches the block over a plain register bus: address, write strobe, write data and combinational read data. A write to the control/status word is only honoured after a separate unlock write. Each control write uses up that unlock, so every later control write needs a fresh unlock.

Top module: `wwin_wdog`

## Requirements
- R1: The register map is byte-addressed and word-aligned. 0x00 is the unlock word (bit 0). 0x04 is control/status: bit 0 = running, bit 8 = open phase active, bit 16 = fault. 0x08 is the closed-phase count, 0x0C is the open-phase count, and 0x10 is a read-only view of the live counter. Any other address reads 0. After reset the unlock word, control/status and live counter read 0, and the counts hold their parameter defaults (0).
- R2: A write to 0x04 has an effect only while unlock bit 0 is 1. Every write to 0x04 clears the unlock bit, whether or not the write was honoured.
- R3: An honoured 0x04 write with bit 0 = 1 while idle loads the counter with the closed count and starts the closed phase. The counter then falls by one each clock. The edge after it reaches 0 loads the open count and sets status bit 8.
- R4: An honoured 0x04 write with bit 8 = 1 during the open phase reloads the closed count and clears bit 8. This holds even on the last open cycle, because the restart takes priority over expiry.
- R5: An honoured 0x04 write with bit 8 = 1 during the closed phase is a fault. The reset request is high for exactly the one cycle after that write edge, and status then reads only bit 16.
- R6: If the open phase reaches 0 without a restart, the block faults in the same way: a one-cycle reset request, and status reads only bit 16.
- R7: An honoured 0x04 write with bits 0 and 8 both 0 stops the watchdog (status reads 0) only during the open phase. During the closed phase such a write is ignored and counting continues.
- R8: Writes to 0x08 and 0x0C are ignored while the watchdog is running (closed or open phase). They are accepted when idle or faulted and read back as written.
- R9: A fault persists until reset. The counter stops, control writes are ignored, and the interrupt output equals status bit 16.
- R10: Writes to 0x10 have no effect. Reads of 0x10 follow the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW (5) | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr |
| wd_reset_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | Fault interrupt flag (level) |

## Verification
The phase sequencer is driven with these restart patterns:
- A restart on the very last open-phase cycle, which separates restart priority from expiry.
- No restart at all, which shows the open-phase timeout.
- A restart early in the closed phase, which shows the early-kick fault.
- A stop request in each phase, which shows that stopping is refused while closed.

Control writes are sent both with and without a preceding unlock, and also after an unlock has already been used, so that the unlock-consumption rule can be told apart from a plain lock bit. Count-register writes are made while running, while idle and while faulted, which separates the freeze rule from a stuck register.

// File: rtl/wwin_pkg.sv
package wwin_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CLOSED = 2'd1,
      PH_OPEN   = 2'd2,
      PH_FAULT  = 2'd3
   } phase_t;

   // byte offsets decoded by software
   localparam int OFS_UNLOCK = 'h00;
   localparam int OFS_CTRL   = 'h04;
   localparam int OFS_CLOSED = 'h08;
   localparam int OFS_OPEN   = 'h0C;
   localparam int OFS_LIVE   = 'h10;

   // control/status bit positions
   localparam int BIT_RUN   = 0;
   localparam int BIT_OPEN  = 8;
   localparam int BIT_FAULT = 16;

endpackage

// File: rtl/wwin_regs.sv
module wwin_regs
   import wwin_pkg::*;
#(
   parameter int AW          = 5,
   parameter int DW          = 32,
   parameter int CLOSED_INIT = 0,
   parameter int OPEN_INIT   = 0,
   parameter int RD_PIPE     = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          running,
   input  logic          stat_open,
   input  logic          stat_fault,
   input  logic [DW-1:0] live_cnt,
   output logic          ctl_wr,
   output logic          ctl_arm,
   output logic          ctl_kick,
   output logic [DW-1:0] win_closed,
   output logic [DW-1:0] win_open
);

   logic hit_unl, hit_ctl, hit_cw, hit_ow, hit_live;
   logic unlock_q;
   logic [DW-1:0] closed_q, open_q;
   logic [DW-1:0] status_w, rd_next;

   assign hit_unl  = (addr == AW'(OFS_UNLOCK));
   assign hit_ctl  = (addr == AW'(OFS_CTRL));
   assign hit_cw   = (addr == AW'(OFS_CLOSED));
   assign hit_ow   = (addr == AW'(OFS_OPEN));
   assign hit_live = (addr == AW'(OFS_LIVE));

   // unlock: set/cleared by its own word, spent by any control write
   always_ff @(posedge clk) begin
      if (rst)
         unlock_q <= 1'b0;
      else if (we && hit_unl)
         unlock_q <= wdata[0];
      else if (we && hit_ctl)
         unlock_q <= 1'b0;
   end

   assign ctl_wr   = we && hit_ctl && unlock_q;
   assign ctl_arm  = wdata[BIT_RUN];
   assign ctl_kick = wdata[BIT_OPEN];

   // phase counts: frozen while the sequencer runs
   always_ff @(posedge clk) begin
      if (rst) begin
         closed_q <= DW'(CLOSED_INIT);
         open_q   <= DW'(OPEN_INIT);
      end else if (we && !running) begin
         if (hit_cw) closed_q <= wdata;
         if (hit_ow) open_q   <= wdata;
      end
   end

   assign win_closed = closed_q;
   assign win_open   = open_q;

   always_comb begin
      status_w            = '0;
      status_w[BIT_RUN]   = running;
      status_w[BIT_OPEN]  = stat_open;
      status_w[BIT_FAULT] = stat_fault;
   end

   always_comb begin
      rd_next = '0;
      if (hit_unl)  rd_next = {{(DW-1){1'b0}}, unlock_q};
      if (hit_ctl)  rd_next = status_w;
      if (hit_cw)   rd_next = closed_q;
      if (hit_ow)   rd_next = open_q;
      if (hit_live) rd_next = live_cnt;
   end

   generate
      if (RD_PIPE == 1) begin : g_rd_reg
         logic [DW-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (rst) rd_q <= '0;
            else     rd_q <= rd_next;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_next;
      end
   endgenerate

   // R2: any control write spends the unlock
   p_unlock_spent_r2: assert property (@(posedge clk) disable iff (rst)
      (we && hit_ctl) |=> !unlock_q);

   // R8: counts hold while running
   p_closed_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      (we && hit_cw && running) |=> $stable(closed_q));
   p_open_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      (we && hit_ow && running) |=> $stable(open_q));

endmodule

// File: rtl/wwin_seq.sv
module wwin_seq
   import wwin_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ctl_wr,
   input  logic          ctl_arm,
   input  logic          ctl_kick,
   input  logic [DW-1:0] win_closed,
   input  logic [DW-1:0] win_open,
   output logic          running,
   output logic          stat_open,
   output logic          stat_fault,
   output logic [DW-1:0] live_cnt,
   output logic          reset_req
);

   phase_t        ph_q, ph_d;
   logic [DW-1:0] cnt_q, cnt_d;
   logic          req_d, req_q;
   logic          at_zero;

   assign at_zero = (cnt_q == '0);

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      req_d = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (ctl_wr && ctl_arm) begin
               ph_d  = PH_CLOSED;
               cnt_d = win_closed;
            end
         end
         PH_CLOSED: begin
            if (ctl_wr && ctl_kick) begin
               ph_d  = PH_FAULT;
               req_d = 1'b1;
            end else if (at_zero) begin
               ph_d  = PH_OPEN;
               cnt_d = win_open;
            end else begin
               cnt_d = cnt_q - DW'(1);
            end
         end
         PH_OPEN: begin
            if (ctl_wr && ctl_kick) begin
               ph_d  = PH_CLOSED;
               cnt_d = win_closed;
            end else if (ctl_wr && !ctl_arm) begin
               ph_d  = PH_IDLE;
            end else if (at_zero) begin
               ph_d  = PH_FAULT;
               req_d = 1'b1;
            end else begin
               cnt_d = cnt_q - DW'(1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
         req_q <= req_d;
      end
   end

   assign running    = (ph_q == PH_CLOSED) || (ph_q == PH_OPEN);
   assign stat_open  = (ph_q == PH_OPEN);
   assign stat_fault = (ph_q == PH_FAULT);
   assign live_cnt   = cnt_q;
   assign reset_req  = req_q;

   // R5/R6: request is a single-cycle pulse
   p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      reset_req |=> !reset_req);
   // R6: a request only accompanies the fault phase
   p_req_in_fault_r6: assert property (@(posedge clk) disable iff (rst)
      reset_req |-> (ph_q == PH_FAULT));
   // R9: fault is sticky
   p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_FAULT) |=> (ph_q == PH_FAULT));
   // R5: early kick faults
   p_early_kick_r5: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_CLOSED && ctl_wr && ctl_kick) |=> reset_req);
   // R4: open-phase kick restarts the closed phase
   p_restart_r4: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_OPEN && ctl_wr && ctl_kick) |=>
      (ph_q == PH_CLOSED && cnt_q == $past(win_closed)));
   // R7: stop refused while closed
   p_no_stop_closed_r7: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_CLOSED && ctl_wr && !ctl_kick) |=> running);

endmodule

// File: rtl/wwin_wdog.sv
module wwin_wdog
   import wwin_pkg::*;
#(
   parameter int AW          = 5,
   parameter int DW          = 32,
   parameter int CLOSED_INIT = 0,
   parameter int OPEN_INIT   = 0,
   parameter int RD_PIPE     = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          wd_reset_req,
   output logic          wd_irq
);

   generate
      if (DW < BIT_FAULT + 1) begin : g_bad_dw
         $error("wwin_wdog: DW must hold the fault status bit");
      end
      if (AW < 5) begin : g_bad_aw
         $error("wwin_wdog: AW too narrow for the register map");
      end
      if (RD_PIPE != 0 && RD_PIPE != 1) begin : g_bad_pipe
         $error("wwin_wdog: RD_PIPE must be 0 or 1");
      end
   endgenerate

   logic          running, stat_open, stat_fault;
   logic          ctl_wr, ctl_arm, ctl_kick;
   logic [DW-1:0] live_cnt, win_closed, win_open;

   wwin_regs #(
      .AW(AW), .DW(DW), .CLOSED_INIT(CLOSED_INIT),
      .OPEN_INIT(OPEN_INIT), .RD_PIPE(RD_PIPE)
   ) u_regs (
      .clk(clk), .rst(rst),
      .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
      .running(running), .stat_open(stat_open), .stat_fault(stat_fault),
      .live_cnt(live_cnt),
      .ctl_wr(ctl_wr), .ctl_arm(ctl_arm), .ctl_kick(ctl_kick),
      .win_closed(win_closed), .win_open(win_open)
   );

   wwin_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst(rst),
      .ctl_wr(ctl_wr), .ctl_arm(ctl_arm), .ctl_kick(ctl_kick),
      .win_closed(win_closed), .win_open(win_open),
      .running(running), .stat_open(stat_open), .stat_fault(stat_fault),
      .live_cnt(live_cnt), .reset_req(wd_reset_req)
   );

   assign wd_irq = stat_fault;

   // R9: interrupt tracks the sticky fault and never drops without reset
   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      wd_irq |=> wd_irq);

endmodule

// File: tb/sim_wwin_wdog.sv
module sim_wwin_wdog;

   localparam int CLK_PER = 10;
   localparam int LIMIT   = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  addr = 5'h10;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rreq, irq;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   // behavioural model state
   int unsigned m_unl, m_cw, m_ow, m_cnt, m_st, m_req;
   int unsigned n_st, n_cnt, n_req;
   bit          cw_hit;

   always #(CLK_PER/2) clk = ~clk;

   wwin_wdog u0 (
      .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata),
      .wd_reset_req(rreq), .wd_irq(irq)
   );

   function automatic int unsigned m_read(input logic [4:0] a);
      case (a)
         5'h00: return m_unl;
         5'h04: return ((m_st == 1 || m_st == 2) ? 32'h1 : 32'h0) |
                       ((m_st == 2) ? 32'h100 : 32'h0) |
                       ((m_st == 3) ? 32'h10000 : 32'h0);
         5'h08: return m_cw;
         5'h0C: return m_ow;
         5'h10: return m_cnt;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // model update and per-cycle comparison
   always @(posedge clk) begin
      if (rst) begin
         m_unl = 0; m_cw = 0; m_ow = 0; m_cnt = 0; m_st = 0; m_req = 0;
      end else begin
         cw_hit = we && addr == 5'h04 && m_unl == 1;
         n_st = m_st; n_cnt = m_cnt; n_req = 0;
         case (m_st)
            0: if (cw_hit && wdata[0]) begin n_st = 1; n_cnt = m_cw; end
            1: if (cw_hit && wdata[8]) begin n_st = 3; n_req = 1; end
               else if (m_cnt == 0) begin n_st = 2; n_cnt = m_ow; end
               else n_cnt = m_cnt - 1;
            2: if (cw_hit && wdata[8]) begin n_st = 1; n_cnt = m_cw; end
               else if (cw_hit && !wdata[0]) n_st = 0;
               else if (m_cnt == 0) begin n_st = 3; n_req = 1; end
               else n_cnt = m_cnt - 1;
            default: ;
         endcase
         if (we && (m_st == 0 || m_st == 3)) begin
            if (addr == 5'h08) m_cw = wdata;
            if (addr == 5'h0C) m_ow = wdata;
         end
         if (we && addr == 5'h00) m_unl = wdata[0];
         else if (we && addr == 5'h04) m_unl = 0;
         m_st = n_st; m_cnt = n_cnt; m_req = n_req;
      end
      #(CLK_PER/4);
      if (!rst) begin
         chk({cur_req, " model rdata"}, rdata, m_read(addr));
         chk({cur_req, " model reset_req"}, 32'(rreq), m_req);
         chk({cur_req, " model irq"}, 32'(irq), (m_st == 3) ? 1 : 0);
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; addr = 5'h10;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      @(posedge clk);
      #(CLK_PER/4);
      chk(tag, rdata, exp);
      @(negedge clk);
      addr = 5'h10;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1: reset state and map
      cur_req = "R1";
      rd_chk(5'h00, 0, "R1 unlock after reset");
      rd_chk(5'h04, 0, "R1 status after reset");
      rd_chk(5'h08, 0, "R1 closed default");
      rd_chk(5'h0C, 0, "R1 open default");
      rd_chk(5'h10, 0, "R1 live after reset");
      rd_chk(5'h14, 0, "R1 unmapped reads zero");
      chk("R1 irq after reset", 32'(irq), 0);

      // R8: program while idle
      cur_req = "R8";
      wr(5'h08, 3);
      wr(5'h0C, 4);
      rd_chk(5'h08, 3, "R8 closed accepted idle");
      rd_chk(5'h0C, 4, "R8 open accepted idle");

      // R2: control write without unlock ignored
      cur_req = "R2";
      wr(5'h04, 1);
      rd_chk(5'h04, 0, "R2 locked write ignored");
      wr(5'h00, 1);
      rd_chk(5'h00, 1, "R2 unlock reads back");

      // R3: enable and phase sequence (C=3, O=4)
      cur_req = "R3";
      wr(5'h04, 1);                                   // E0: cnt 3
      rd_chk(5'h00, 0, "R2 unlock spent");            // E1: cnt 2
      rd_chk(5'h04, 1, "R3 closed phase running");    // E2: cnt 1
      rd_chk(5'h10, 0, "R3 closed count at zero");    // E3: cnt 0
      rd_chk(5'h04, 32'h101, "R3 open phase entered"); // E4: cnt 4
      rd_chk(5'h10, 3, "R10 live count in open");     // E5: cnt 3
      cur_req = "R8";
      wr(5'h08, 9);                                   // E6: ignored
      rd_chk(5'h08, 3, "R8 closed frozen while running"); // E7
      // R4: restart on the last open cycle
      cur_req = "R4";
      wr(5'h00, 1);                                   // E8: cnt 0
      wr(5'h04, 32'h101);                             // E9: restart
      rd_chk(5'h04, 1, "R4 restart back in closed");  // E10: cnt 2
      rd_chk(5'h10, 1, "R4 closed count reloaded");   // E11: cnt 1

      // R6: expiry of open phase
      cur_req = "R6";
      repeat (12) @(negedge clk);
      rd_chk(5'h04, 32'h10000, "R6 fault after open expiry");
      chk("R9 irq equals fault bit", 32'(irq), 1);

      // R9: fault is sticky, control ignored
      cur_req = "R9";
      wr(5'h00, 1);
      wr(5'h04, 1);
      rd_chk(5'h04, 32'h10000, "R9 control ignored in fault");
      cur_req = "R8";
      wr(5'h08, 7);
      rd_chk(5'h08, 7, "R8 closed accepted in fault");

      // reset clears fault
      cur_req = "R1";
      do_reset();
      rd_chk(5'h04, 0, "R1 status cleared by reset");
      rd_chk(5'h08, 0, "R1 closed restored by reset");

      // R5: early kick in closed phase
      cur_req = "R5";
      wr(5'h08, 20);
      wr(5'h0C, 5);
      wr(5'h00, 1);
      wr(5'h04, 1);
      repeat (2) @(negedge clk);
      wr(5'h00, 1);
      addr = 5'h04; wdata = 32'h100; we = 1'b1;
      @(posedge clk);
      #(CLK_PER/4);
      chk("R5 reset request after early kick", 32'(rreq), 1);
      @(negedge clk);
      we = 1'b0; addr = 5'h10;
      chk("R5 reset request one cycle only", 32'(rreq), 1);
      rd_chk(5'h04, 32'h10000, "R5 fault status");
      chk("R5 reset request dropped", 32'(rreq), 0);

      // R7: stop refused in closed, accepted in open
      cur_req = "R7";
      do_reset();
      wr(5'h08, 10);
      wr(5'h0C, 30);
      wr(5'h00, 1);
      wr(5'h04, 1);
      wr(5'h00, 1);
      wr(5'h04, 0);
      rd_chk(5'h04, 1, "R7 stop ignored in closed");
      repeat (12) @(negedge clk);
      rd_chk(5'h04, 32'h101, "R7 reached open phase");
      wr(5'h00, 1);
      wr(5'h04, 0);
      rd_chk(5'h04, 0, "R7 stop accepted in open");
      cur_req = "R2";
      wr(5'h04, 1);
      rd_chk(5'h04, 0, "R2 no unlock after stop");

      // R10: live register read-only
      cur_req = "R10";
      wr(5'h10, 32'hFFFF);
      rd_chk(5'h0C, 30, "R10 write to live reg touched nothing");
      repeat (3) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule